// File: doc/BRIEF.md
# DSCP to TID Classification Table

This block turns a 6-bit differentiated-services code point into a 3-bit traffic identifier. It keeps 32 separate mapping tables. A lookup port names one table and one code point, and one clock later it returns the identifier stored for that pair. A host programs the tables through a small register bus. The bus has an address, write data, a write strobe and registered read data.

Each table is a bitstream of 192 bits, packed into six consecutive 32-bit words. The 3-bit entries run back to back with no padding, so some entries are split across two words. Table writes are accepted only while a program-enable bit is set in a control register. That register sits at its own address. The host changes one entry with a read-modify-write through the bus, and it reprograms a whole table by writing its six words in order.

Top module: `dscp_tid_map`

## Requirements
- R1: After reset every table word reads 0, every lookup returns TID 0, and the control register reads 0.
- R2: Table n occupies word addresses 6n to 6n+5. The entry for code point d is bit field [3d+2:3d] of the table's 192-bit stream, with stream bit k held in word 6n + k/32 at bit k%32. The lookup result for (id, d) appears on `lk_tid` on the clock edge after id and d are presented.
- R3: The entries for code points 10, 21, 42 and 53 each span two words: their low bits are the top bits of one word and their high bits are the bottom bits of the next word. The lookup returns them reassembled, and rewriting one of them leaves entries 9 and 11 (and the corresponding neighbours of 21, 42 and 53) unchanged.
- R4: A lookup with a table id of 32 or more returns TID 0. Writes to addresses 192 to 254 change nothing, and reads of those addresses return 0.
- R5: A write to a table word takes effect only while bit 0 (program enable) of the control register is 1. While that bit is 0, table writes are dropped without effect.
- R6: The control register is at address 255. All 32 of its bits read back as written. Only bit 0 has any effect.
- R7: Read data is registered: `reg_rdata` shows the content of the address presented one edge earlier, and it shows the content from before any write made on that same edge. Table words can be read whatever the state of program enable.
- R8: A lookup presented on the same edge as a write to the word that holds its entry returns the entry's value from before the write. The next lookup returns the new value.
- R9: When a table is loaded by packing each group of 8 consecutive entries into 24 bits, chaining the groups into a byte stream, and writing the stream as six little-endian 32-bit words in ascending address order, every entry of that table reads back through the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register word address: 0 to 191 are table words, 255 is the control register |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Registered read data for the address presented one edge earlier |
| lk_id | input | 6 | Table id for the lookup |
| lk_dscp | input | 6 | Code point for the lookup |
| lk_tid | output | 3 | Registered traffic identifier |

## Verification
The bench targets the four split entries. A design that sliced each word on its own would return those entries with missing or wrong high bits, and a read-modify-write could spill into entry 9 or entry 11. The bench drives ids 32 and 63 to confirm the table select does not wrap onto real tables. It also drives writes to the unmapped addresses and to table words while program enable is clear, because an ungated write path would change table contents there. A lookup on the same edge as a write to its own word exposes a design that forwards the new value, or that updates late.

// File: rtl/dscp_tid_map.sv
module dscp_tid_map #(
  parameter int N_TABLES  = 32,
  parameter int N_CODES   = 64,
  parameter int TID_W     = 3,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int ID_W      = 6,
  parameter int CTRL_ADDR = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_we,
  output logic [DW-1:0]   reg_rdata,
  input  logic [ID_W-1:0] lk_id,
  input  logic [$clog2(N_CODES)-1:0] lk_dscp,
  output logic [TID_W-1:0] lk_tid
);
  localparam int WPT      = (N_CODES * TID_W + DW - 1) / DW;
  localparam int MW       = N_TABLES * WPT;
  localparam int TBL_BITS = WPT * DW;

  logic [DW-1:0] map_q [MW];
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] rdata_q;
  logic [TID_W-1:0] tid_q;

  wire prog_en  = ctrl_q[0];
  wire hit_ctrl = (32'(reg_addr) == CTRL_ADDR);
  wire hit_map  = (32'(reg_addr) < MW);
  wire id_ok    = (32'(lk_id) < N_TABLES);

  logic [AW-1:0]       base;
  logic [TBL_BITS-1:0] tbl_vec;

  assign base = id_ok ? AW'(32'(lk_id) * WPT) : '0;

  for (genvar w = 0; w < WPT; w++) begin : g_word
    assign tbl_vec[w*DW +: DW] = map_q[32'(base) + w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) map_q[i] <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
      tid_q   <= '0;
    end else begin
      if (reg_we && hit_ctrl) ctrl_q <= reg_wdata;
      if (reg_we && hit_map && prog_en) map_q[reg_addr] <= reg_wdata;
      rdata_q <= hit_ctrl ? ctrl_q : (hit_map ? map_q[reg_addr] : '0);
      tid_q   <= id_ok ? tbl_vec[32'(lk_dscp) * TID_W +: TID_W] : '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign lk_tid    = tid_q;
endmodule

// File: rtl/dscp_tid_map_chk.sv
module dscp_tid_map_chk #(
  parameter int N_TABLES  = 32,
  parameter int N_CODES   = 64,
  parameter int TID_W     = 3,
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int ID_W      = 6,
  parameter int CTRL_ADDR = 255
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic            reg_we,
  input logic [DW-1:0]   reg_rdata,
  input logic [ID_W-1:0] lk_id,
  input logic [TID_W-1:0] lk_tid
);
  localparam int WPT = (N_CODES * TID_W + DW - 1) / DW;
  localparam int MW  = N_TABLES * WPT;

  a_r1_reset_tid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lk_tid == '0);

  a_r4_bad_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lk_id) >= N_TABLES) |=> lk_tid == '0);

  a_r4_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(reg_addr) >= MW && 32'(reg_addr) != CTRL_ADDR) |=> reg_rdata == '0);

  a_r6_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && 32'(reg_addr) == CTRL_ADDR) ##1 (!reg_we && 32'(reg_addr) == CTRL_ADDR)
      |=> reg_rdata == $past(reg_wdata, 2));
endmodule

bind dscp_tid_map dscp_tid_map_chk #(
  .N_TABLES(N_TABLES), .N_CODES(N_CODES), .TID_W(TID_W), .DW(DW),
  .AW(AW), .ID_W(ID_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .lk_id(lk_id), .lk_tid(lk_tid)
);

// File: tb/tb_dscp_tid_map.sv
`timescale 1ns/1ps
module tb_dscp_tid_map;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_we = 0;
  logic [31:0] reg_rdata;
  logic [5:0]  lk_id = 0;
  logic [5:0]  lk_dscp = 0;
  logic [2:0]  lk_tid;

  always #4 clk = ~clk;

  dscp_tid_map dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .lk_id(lk_id), .lk_dscp(lk_dscp), .lk_tid(lk_tid));

  int total = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  int          ent [32][64];
  logic [31:0] m_ctrl;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word(input int a);
    logic [31:0] v = 0;
    if (a == 255) return m_ctrl;
    if (a >= 192) return 0;
    for (int b = 0; b < 32; b++) begin
      int pos = 32 * (a % 6) + b;
      v[b] = ent[a / 6][pos / 3][pos % 3];
    end
    return v;
  endfunction

  task automatic m_write(input int a, input logic [31:0] d);
    if (a == 255) m_ctrl = d;
    else if (a < 192 && m_ctrl[0]) begin
      for (int b = 0; b < 32; b++) begin
        int pos = 32 * (a % 6) + b;
        int e = pos / 3;
        int k = pos % 3;
        ent[a / 6][e] = (ent[a / 6][e] & ~(1 << k)) | (int'(d[b]) << k);
      end
    end
  endtask

  // per-clock reference comparison
  logic [31:0] e_rd;
  int          e_lk;
  bit          have = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      have = 0;
      m_ctrl = 0;
      for (int t = 0; t < 32; t++) for (int d = 0; d < 64; d++) ent[t][d] = 0;
    end else begin
      e_rd = m_word(int'(reg_addr));
      e_lk = (lk_id < 32) ? ent[lk_id][lk_dscp] : 0;
      if (reg_we) m_write(int'(reg_addr), reg_wdata);
      have = 1;
    end
    #2;
    if (have && rst_n) begin
      chk(reg_rdata == e_rd, {phase, " rdata"}, reg_rdata, e_rd);
      chk(32'(lk_tid) == 32'(e_lk), {phase, " lookup"}, 32'(lk_tid), 32'(e_lk));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_addr = 8'(a); reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_we = 0; reg_addr = 8'(a);
    @(posedge clk); #2; d = reg_rdata;
  endtask

  task automatic look(input int id, input int c, output int t);
    @(negedge clk); lk_id = 6'(id); lk_dscp = 6'(c);
    @(posedge clk); #2; t = int'(lk_tid);
  endtask

  function automatic int pat(input int t, input int d);
    return (d * 3 + t + d / 7) % 8;
  endfunction

  // R9 style load: 8 entries -> 24 bits, byte stream, little-endian words
  task automatic load_table(input int t);
    logic [7:0] bytes [24];
    for (int g = 0; g < 8; g++) begin
      logic [23:0] v = 0;
      for (int i = 0; i < 8; i++) v = v | (24'(pat(t, 8*g+i)) << (3*i));
      bytes[3*g] = v[7:0]; bytes[3*g+1] = v[15:8]; bytes[3*g+2] = v[23:16];
    end
    for (int w = 0; w < 6; w++)
      wr(t*6 + w, {bytes[4*w+3], bytes[4*w+2], bytes[4*w+1], bytes[4*w]});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w0, w1;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    phase = "R1";
    rd(255, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(0, d);   chk(d == 0, "R1 word0", d, 0);
    rd(191, d); chk(d == 0, "R1 word191", d, 0);
    look(31, 63, t); chk(t == 0, "R1 lookup", t, 0);

    // R5 locked write ignored
    phase = "R5";
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk(d == 0, "R5 locked write", d, 0);
    look(0, 20, t); chk(t == 0, "R5 locked lookup", t, 0);

    // R6 control readback, only bit 0 matters
    phase = "R6";
    wr(255, 32'hA5A5_0000);
    rd(255, d); chk(d == 32'hA5A5_0000, "R6 ctrl readback", d, 32'hA5A5_0000);
    wr(4, 32'h1234_5678);
    rd(4, d); chk(d == 0, "R6 upper bits no effect", d, 0);
    wr(255, 32'h5A5A_0001);
    rd(255, d); chk(d == 32'h5A5A_0001, "R6 ctrl readback 2", d, 32'h5A5A_0001);

    // R9 / R2 full table loads and lookups
    phase = "R9";
    load_table(5); load_table(0); load_table(31);
    phase = "R2";
    for (int c = 0; c < 64; c++) begin
      look(5, c, t); chk(t == pat(5, c), "R2 table5 entry", t, pat(5, c));
    end
    for (int c = 0; c < 64; c += 9) begin
      look(31, c, t); chk(t == pat(31, c), "R2 table31 entry", t, pat(31, c));
      look(0, c, t);  chk(t == pat(0, c), "R2 table0 entry", t, pat(0, c));
    end

    // R3 split entries and RMW of entry 10
    phase = "R3";
    foreach (ent[0][k]) if (k == 10 || k == 21 || k == 42 || k == 53) begin
      look(5, k, t); chk(t == pat(5, k), "R3 split entry", t, pat(5, k));
    end
    for (int w = 0; w < 6; w++) wr(42 + w, 32'hFFFF_FFFF);
    rd(42, w0); rd(43, w1);
    w0 = {2'b10, w0[29:0]};
    w1 = {w1[31:1], 1'b0};
    wr(42, w0); wr(43, w1);
    look(7, 10, t); chk(t == 2, "R3 rmw entry10", t, 2);
    look(7, 9, t);  chk(t == 7, "R3 neighbour 9", t, 7);
    look(7, 11, t); chk(t == 7, "R3 neighbour 11", t, 7);

    // R4 out of range id and unmapped addresses
    phase = "R4";
    look(32, 5, t); chk(t == 0, "R4 id 32", t, 0);
    look(63, 0, t); chk(t == 0, "R4 id 63", t, 0);
    wr(200, 32'hDEAD_BEEF);
    rd(200, d); chk(d == 0, "R4 hole read", d, 0);
    rd(0, d); chk(d == m_word(0), "R4 word0 untouched", d, m_word(0));

    // R8 lookup same edge as write
    phase = "R8";
    @(negedge clk);
    lk_id = 5; lk_dscp = 2; reg_addr = 30; reg_wdata = 0; reg_we = 1;
    @(posedge clk); #2;
    chk(32'(lk_tid) == 32'(pat(5, 2)), "R8 old value", 32'(lk_tid), 32'(pat(5, 2)));
    @(negedge clk); reg_we = 0;
    @(posedge clk); #2;
    chk(lk_tid == 0, "R8 new value", 32'(lk_tid), 0);

    // R7 read old data on write edge; read while locked
    phase = "R7";
    @(negedge clk); reg_addr = 31; reg_wdata = 32'h0F0F_0F0F; reg_we = 1;
    w0 = m_word(31);
    @(posedge clk); #2;
    chk(reg_rdata == w0, "R7 pre-write read", reg_rdata, w0);
    @(negedge clk); reg_we = 0;
    @(posedge clk); #2;
    chk(reg_rdata == 32'h0F0F_0F0F, "R7 post-write read", reg_rdata, 32'h0F0F_0F0F);
    wr(255, 32'h0);
    phase = "R5";
    wr(31, 32'h0);
    phase = "R7";
    rd(31, d); chk(d == 32'h0F0F_0F0F, "R7 read while locked", d, 32'h0F0F_0F0F);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule